// File: doc/BRIEF.md
# I2C Target Bit-to-Byte Bridge

This block sits on the target side of a two-wire serial bus. It oversamples the clock line and data line that a bus controller drives, recovers START and STOP conditions and data bits, and turns them into single-cycle byte events for a device model further downstream. The events are: transfer opened (7-bit address plus direction), byte written, byte requested for reading, controller refused a read byte, and transfer closed. The block accepts every address. It has no address of its own and leaves the decision to the downstream model.

The block has its own open-drain data output. A 0 pulls the line low and a 1 releases it. It drives the acknowledge bit and the read data bits from the clock rising edge it observes, and it releases the line on every clock falling edge. It also reports the wire-AND of its own output and the controller's data level. A one-cycle notice goes out whenever that resolved level changes.

Both bus inputs pass through synchronizers whose depth is a parameter. When a data edge and a clock edge arrive in the same system clock cycle, the data edge is evaluated first, against the clock level from the previous sample.

Top module: `i2c_byte_bridge`

## Requirements
- R1: After reset, `sda_drive_o` and `sda_res_o` are 1, `sda_chg_o` is 0, and no event strobe is active.
- R2: The first full byte after a START raises `xfer_start_o` once, on its ninth clock rising edge. `xfer_addr_o` holds the first seven bits received, MSB first, and `xfer_read_o` holds the eighth bit (1 means read). The block drives 0 (ACK) during that ninth clock high phase.
- R3: In write direction, each later byte is shifted in MSB first and raises `wr_stb_o` on its ninth clock rising edge with the byte on `wr_data_o`. The block drives ACK (0) for that slot.
- R4: In read direction, `rd_req_o` pulses on the first clock rising edge of each read byte, and `rd_data_i` is taken in that same cycle. The block then drives the byte MSB first, one bit per clock rising edge, and the bit stays on the line through the high phase.
- R5: In the ninth slot of a read byte, a controller data level of 0 (acknowledge) makes the next byte a read: a new `rd_req_o` at the next first bit.
- R6: In the ninth slot of a read byte, a controller data level of 1 raises `nack_o`. Further clock pulses then produce no strobe, and the block's output stays released, until a START or STOP arrives.
- R7: A STOP (data rises while clock is high) raises `end_o` only when an address has been received since the last START. A STOP while idle produces no strobe.
- R8: Data changes while the clock is low change no state. Glitching the data line during the low phase of an address bit still gives the address set up before the clock rises.
- R9: The block releases its output (drives 1) after every clock falling edge.
- R10: `sda_chg_o` pulses for one cycle, one cycle after `sda_res_o` changes, and at no other time.
- R11: A repeated START in the middle of a transfer produces no `end_o`. The next byte is treated as a new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock level from the controller |
| sda_i | input | 1 | Data level driven by the controller |
| sda_drive_o | output | 1 | Block's open-drain data output (0 pulls low) |
| sda_res_o | output | 1 | Resolved data level (output AND controller level) |
| sda_chg_o | output | 1 | One-cycle notice of a change in the resolved level |
| xfer_start_o | output | 1 | Transfer opened strobe |
| xfer_addr_o | output | BYTE_W-1 | Address, valid with `xfer_start_o` |
| xfer_read_o | output | 1 | Direction, valid with `xfer_start_o` (1 = read) |
| wr_stb_o | output | 1 | Write byte strobe |
| wr_data_o | output | BYTE_W | Write byte, valid with `wr_stb_o` |
| rd_req_o | output | 1 | Read byte request strobe |
| rd_data_i | input | BYTE_W | Read byte, sampled while `rd_req_o` is high |
| nack_o | output | 1 | Controller refused the read byte |
| end_o | output | 1 | Transfer closed strobe |

## Verification
The state that is hardest to reach from the ports is the refused-read state. The bench gets there by opening a read transfer, taking one byte with an acknowledge and refusing the second. It then clocks further bits with both data levels and checks that no event appears and that the resolved line follows only the controller. A second path opens a write, sends data, and issues a repeated START while the block is in write direction. The next byte must reopen as a read with no close event in between. Glitches in the clock low phase are placed inside an address byte, so a wrong capture would show up in the reported address.

// File: rtl/i2cbb_pkg.sv
package i2cbb_pkg;
   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_WR     = 3'd1,
      ST_ACKW   = 3'd2,
      ST_RD     = 3'd3,
      ST_RACK   = 3'd4,
      ST_NACKED = 3'd5
   } bb_state_e;
endpackage

// File: rtl/i2cbb_sync.sv
module i2cbb_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   initial begin
      if (STAGES < 2) $error("i2cbb_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   genvar g;
   generate
      for (g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b1;
               else        chain[0] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[g] <= 1'b1;
               else        chain[g] <= chain[g-1];
            end
         end
      end
   endgenerate

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/i2cbb_edge.sv
module i2cbb_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic cond_start,
   output logic cond_stop,
   output logic clk_rise,
   output logic clk_fall,
   output logic sda_now,
   output logic sda_last
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   // data edge is judged against the previous clock level (data first)
   assign cond_start = (sda_s != sda_q) && scl_q && !sda_s;
   assign cond_stop  = (sda_s != sda_q) && scl_q &&  sda_s;
   assign clk_rise   = scl_s && !scl_q;
   assign clk_fall   = !scl_s && scl_q;
   assign sda_now    = sda_s;
   assign sda_last   = sda_q;
endmodule

// File: rtl/i2cbb_fsm.sv
module i2cbb_fsm
   import i2cbb_pkg::*;
#(
   parameter int BYTE_W = 8,
   localparam int ADDR_W = BYTE_W - 1,
   localparam int CNT_W  = $clog2(BYTE_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cond_start,
   input  logic              cond_stop,
   input  logic              clk_rise,
   input  logic              clk_fall,
   input  logic              sda_now,
   output logic              drive_o,
   output logic              xfer_start_o,
   output logic [ADDR_W-1:0] xfer_addr_o,
   output logic              xfer_read_o,
   output logic              wr_stb_o,
   output logic [BYTE_W-1:0] wr_data_o,
   output logic              rd_req_o,
   input  logic [BYTE_W-1:0] rd_data_i,
   output logic              nack_o,
   output logic              end_o
);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

   bb_state_e         st, st_n;
   logic [CNT_W-1:0]  cnt, cnt_n;
   logic [BYTE_W-1:0] sh, sh_n, word;
   logic              drv_n, av, av_n, rdm, rdm_n;

   always_comb begin
      st_n  = st;
      cnt_n = cnt;
      sh_n  = sh;
      drv_n = drive_o;
      av_n  = av;
      rdm_n = rdm;
      word  = sh;
      xfer_start_o = 1'b0;
      wr_stb_o     = 1'b0;
      rd_req_o     = 1'b0;
      nack_o       = 1'b0;
      end_o        = 1'b0;
      if (cond_start) begin
         st_n  = ST_WR;
         cnt_n = '0;
         av_n  = 1'b0;
         drv_n = 1'b1;
      end else if (cond_stop) begin
         end_o = av;
         av_n  = 1'b0;
         st_n  = ST_IDLE;
         drv_n = 1'b1;
      end else if (clk_fall) begin
         drv_n = 1'b1;
      end else if (clk_rise) begin
         unique case (st)
            ST_WR: begin
               sh_n  = {sh[BYTE_W-2:0], sda_now};
               drv_n = 1'b1;
               if (cnt == LAST_BIT) begin
                  st_n  = ST_ACKW;
                  cnt_n = '0;
               end else begin
                  cnt_n = cnt + 1'b1;
               end
            end
            ST_ACKW: begin
               drv_n = 1'b0;
               cnt_n = '0;
               if (!av) begin
                  xfer_start_o = 1'b1;
                  av_n  = 1'b1;
                  rdm_n = sh[0];
                  st_n  = sh[0] ? ST_RD : ST_WR;
               end else begin
                  wr_stb_o = 1'b1;
                  st_n     = rdm ? ST_RD : ST_WR;
               end
            end
            ST_RD: begin
               if (cnt == '0) begin
                  rd_req_o = 1'b1;
                  word     = rd_data_i;
               end
               drv_n = word[BYTE_W-1];
               sh_n  = {word[BYTE_W-2:0], 1'b0};
               if (cnt == LAST_BIT) begin
                  st_n  = ST_RACK;
                  cnt_n = '0;
               end else begin
                  cnt_n = cnt + 1'b1;
               end
            end
            ST_RACK: begin
               drv_n = 1'b1;
               cnt_n = '0;
               if (sda_now) begin
                  nack_o = 1'b1;
                  st_n   = ST_NACKED;
               end else begin
                  st_n = ST_RD;
               end
            end
            default: drv_n = 1'b1;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         cnt     <= '0;
         sh      <= '0;
         drive_o <= 1'b1;
         av      <= 1'b0;
         rdm     <= 1'b0;
      end else begin
         st      <= st_n;
         cnt     <= cnt_n;
         sh      <= sh_n;
         drive_o <= drv_n;
         av      <= av_n;
         rdm     <= rdm_n;
      end
   end

   assign xfer_addr_o = sh[BYTE_W-1:1];
   assign xfer_read_o = sh[0];
   assign wr_data_o   = sh;

   assert_one_event_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({xfer_start_o, wr_stb_o, rd_req_o, nack_o, end_o}));
   assert_ack_driven_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_start_o || wr_stb_o) |=> !drive_o);
   assert_read_msb_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_o |=> drive_o == $past(rd_data_i[BYTE_W-1]));
   assert_nack_enter_R6: assert property (@(posedge clk) disable iff (!rst_n)
      nack_o |=> st == ST_NACKED);
   assert_nack_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_NACKED && !cond_start && !cond_stop) |=> drive_o && st == ST_NACKED);
   assert_fall_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
      clk_fall |=> drive_o);
endmodule

// File: rtl/i2c_byte_bridge.sv
module i2c_byte_bridge #(
   parameter int BYTE_W      = 8,
   parameter int SYNC_STAGES = 2,
   localparam int ADDR_W     = BYTE_W - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_drive_o,
   output logic              sda_res_o,
   output logic              sda_chg_o,
   output logic              xfer_start_o,
   output logic [ADDR_W-1:0] xfer_addr_o,
   output logic              xfer_read_o,
   output logic              wr_stb_o,
   output logic [BYTE_W-1:0] wr_data_o,
   output logic              rd_req_o,
   input  logic [BYTE_W-1:0] rd_data_i,
   output logic              nack_o,
   output logic              end_o
);
   initial begin
      if (BYTE_W < 2)      $error("i2c_byte_bridge: BYTE_W must be at least 2");
      if (SYNC_STAGES < 2) $error("i2c_byte_bridge: SYNC_STAGES must be at least 2");
   end

   logic scl_s, sda_s;
   logic c_start, c_stop, c_rise, c_fall, sda_now, sda_last;
   logic res_prev, chg_q;

   i2cbb_sync #(.STAGES(SYNC_STAGES)) u_sync_scl (
      .clk(clk), .rst_n(rst_n), .d_i(scl_i), .q_o(scl_s));
   i2cbb_sync #(.STAGES(SYNC_STAGES)) u_sync_sda (
      .clk(clk), .rst_n(rst_n), .d_i(sda_i), .q_o(sda_s));

   i2cbb_edge u_edge (
      .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
      .cond_start(c_start), .cond_stop(c_stop), .clk_rise(c_rise),
      .clk_fall(c_fall), .sda_now(sda_now), .sda_last(sda_last));

   i2cbb_fsm #(.BYTE_W(BYTE_W)) u_fsm (
      .clk(clk), .rst_n(rst_n),
      .cond_start(c_start), .cond_stop(c_stop),
      .clk_rise(c_rise), .clk_fall(c_fall), .sda_now(sda_now),
      .drive_o(sda_drive_o),
      .xfer_start_o(xfer_start_o), .xfer_addr_o(xfer_addr_o),
      .xfer_read_o(xfer_read_o), .wr_stb_o(wr_stb_o), .wr_data_o(wr_data_o),
      .rd_req_o(rd_req_o), .rd_data_i(rd_data_i),
      .nack_o(nack_o), .end_o(end_o));

   assign sda_res_o = sda_drive_o & sda_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_prev <= 1'b1;
         chg_q    <= 1'b0;
      end else begin
         res_prev <= sda_res_o;
         chg_q    <= sda_res_o != res_prev;
      end
   end
   assign sda_chg_o = chg_q;

   assert_chg_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
      sda_chg_o |-> $past(sda_res_o) != $past(sda_res_o, 2));
endmodule

// File: tb/i2c_byte_bridge_tb.sv
module i2c_byte_bridge_tb;
   localparam int Q = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1, sda = 1'b1;
   logic [7:0] rdat = 8'h00;
   logic drv, res, chg, xs, xr, ws, rq, nk, en;
   logic [6:0] xa;
   logic [7:0] wd;

   int checks = 0, fails = 0;
   bit done = 0;
   logic [11:0] expq[$];
   logic chg_exp = 1'b0, res_prev = 1'b1;

   always #10 clk = ~clk;

   i2c_byte_bridge u_dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
      .sda_drive_o(drv), .sda_res_o(res), .sda_chg_o(chg),
      .xfer_start_o(xs), .xfer_addr_o(xa), .xfer_read_o(xr),
      .wr_stb_o(ws), .wr_data_o(wd), .rd_req_o(rq), .rd_data_i(rdat),
      .nack_o(nk), .end_o(en));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // kinds: 1 open {addr,rw}, 2 write byte, 3 read request, 4 refusal, 5 close
   task automatic expect_ev(input int kind, input int data);
      expq.push_back({kind[3:0], data[7:0]});
   endtask

   // monitor
   always @(negedge clk) begin
      if (rst_n && !done) begin
         logic [11:0] got, e;
         got = 12'h0;
         if (xs)      got = {4'd1, xa, xr};
         else if (ws) got = {4'd2, wd};
         else if (rq) got = {4'd3, 8'h00};
         else if (nk) got = {4'd4, 8'h00};
         else if (en) got = {4'd5, 8'h00};
         if (got != 12'h0) begin
            if (expq.size() == 0) chk(0, "R2/R6/R7 unexpected event", got, 0);
            else begin
               e = expq.pop_front();
               chk(got == e, "R2-event-order event", got, e);
            end
         end
         if (chg_exp || chg) chk(chg == chg_exp, "R10 change notice", chg, chg_exp);
         chg_exp  = (res != res_prev);
         res_prev = res;
      end
   end

   task automatic step(input logic c, input logic d);
      scl = c; sda = d;
      repeat (Q) @(posedge clk);
      #1;
   endtask

   task automatic bus_start;
      step(scl, 1'b1);
      step(1'b1, 1'b1);
      step(1'b1, 1'b0);
      step(1'b0, 1'b0);
   endtask

   task automatic bus_stop;
      step(1'b0, 1'b0);
      step(1'b1, 1'b0);
      step(1'b1, 1'b1);
   endtask

   task automatic bit_io(input logic b, input bit glitch, output logic seen);
      if (glitch) begin
         step(1'b0, ~b);
         step(1'b0, b);
         step(1'b0, ~b);
      end
      step(1'b0, b);
      step(1'b1, b);
      seen = res;
      step(1'b0, b);
   endtask

   task automatic wbyte(input logic [7:0] v, input bit glitch, input string req);
      logic s;
      for (int i = 7; i >= 0; i--) bit_io(v[i], glitch, s);
      bit_io(1'b1, 1'b0, s);
      chk(s == 1'b0, req, s, 0);
      chk(drv == 1'b1, "R9 released after fall", drv, 1);
   endtask

   task automatic rbyte(input logic [7:0] v, input logic ackb);
      logic s;
      rdat = v;
      expect_ev(3, 0);
      for (int i = 7; i >= 0; i--) begin
         bit_io(1'b1, 1'b0, s);
         chk(s == v[i], "R4 read bit", s, v[i]);
      end
      if (ackb) expect_ev(4, 0);
      bit_io(ackb, 1'b0, s);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic s;
      repeat (3) @(posedge clk);
      #1;
      chk(drv == 1 && res == 1 && chg == 0, "R1 reset outputs", {drv, res, chg}, 3'b110);
      chk({xs, ws, rq, nk, en} == 0, "R1 no strobes", {xs, ws, rq, nk, en}, 0);
      rst_n = 1'b1;
      repeat (4) @(posedge clk);
      #1;

      // write transfer, address byte glitched in low phase (R8)
      bus_start;
      expect_ev(1, {7'h50, 1'b0});
      wbyte(8'hA0, 1'b1, "R2 R8 address ACK");
      expect_ev(2, 8'h3C);
      wbyte(8'h3C, 1'b0, "R3 write ACK");
      expect_ev(2, 8'hC3);
      wbyte(8'hC3, 1'b0, "R3 write ACK");
      expect_ev(5, 0);
      bus_stop;
      chk(expq.size() == 0, "R7 close after write", expq.size(), 0);

      // read transfer: ack then refuse
      bus_start;
      expect_ev(1, {7'h21, 1'b1});
      wbyte(8'h43, 1'b0, "R2 read address ACK");
      rbyte(8'h96, 1'b0);
      rbyte(8'h5A, 1'b1);
      chk(expq.size() == 0, "R5 R6 read sequence", expq.size(), 0);
      bit_io(1'b0, 1'b0, s);
      chk(s == 1'b0, "R6 follows controller low", s, 0);
      bit_io(1'b1, 1'b0, s);
      chk(s == 1'b1, "R6 released after refusal", s, 1);
      bit_io(1'b1, 1'b0, s);
      chk(drv == 1'b1, "R6 output released", drv, 1);
      expect_ev(5, 0);
      bus_stop;
      chk(expq.size() == 0, "R7 close after refusal", expq.size(), 0);

      // stop while idle: no event
      bus_stop;
      chk(expq.size() == 0 && drv == 1, "R7 idle stop silent", expq.size(), 0);

      // repeated start mid write
      bus_start;
      expect_ev(1, {7'h11, 1'b0});
      wbyte(8'h22, 1'b0, "R2 address ACK");
      expect_ev(2, 8'h77);
      wbyte(8'h77, 1'b0, "R3 write ACK");
      bus_start;
      expect_ev(1, {7'h11, 1'b1});
      wbyte(8'h23, 1'b0, "R11 new address ACK");
      rbyte(8'hF0, 1'b1);
      expect_ev(5, 0);
      bus_stop;
      chk(expq.size() == 0, "R11 no early close", expq.size(), 0);

      repeat (4) @(posedge clk);
      done = 1;
      $display("  test done: total=%0d bad=%0d", checks, fails);
      $finish;
   end
endmodule